// File: doc/BRIEF.md
# Dual-Latch Serial Control Receiver

This block receives control words for a frequency-synthesizer controller over a three-wire serial link made of a chip-enable line, a serial clock and a data line. While chip enable is high, each rising edge of the serial clock captures one data bit, least significant bit first. A frame opens with a 4-bit mode code and continues with a 17-bit payload. When chip enable falls, the mode code chooses one of two holding latches, and the payload is copied into that latch.

The first latch holds the reference-divider settings: a 12-bit reference ratio, a divide-by-two select, a run/power-save bit, the level of the output-port pin, the charge-pump enable and a test bit. The second latch holds the 17-bit programmable-divider ratio. Every latched field leaves the block as a registered output, ready for the divider and phase-detector logic. A frame is discarded, and both latches keep their old contents, when its mode code is undefined or when its bit count does not match the length for its mode. Frames are accepted in power-save mode as well.

The three serial inputs are asynchronous to the system clock. Each passes through a synchronizer, and all edge detection is done in the system-clock domain.

Top module: `sctl_rx`

## Requirements
- R1: After reset, `pwr_norm` is 0 (power save), `cp_en` is 0 (pump high impedance), `port_out` is 0, and `ref_ratio`, `ref_div2`, `test_flag` and `prog_ratio` are all 0.
- R2: A data bit is taken only on a rising edge of `ser_clk` while `ser_ce` is high. A rising edge of `ser_ce` clears the bit count of the frame.
- R3: Frame bits arrive least significant bit first. Bits 0 to 3 form the mode code. Code 1 selects the reference latch and code 2 selects the programmable latch. Both kinds of frame are 21 bits long.
- R4: On the falling edge of `ser_ce`, a valid reference frame loads frame bits 4 to 15 into `ref_ratio` (bit 4 is the least significant), bit 16 into `ref_div2`, bit 17 into `pwr_norm`, bit 18 into `port_out`, bit 19 into `cp_en` and bit 20 into `test_flag`.
- R5: On the falling edge of `ser_ce`, a valid programmable frame loads frame bits 4 to 20 into `prog_ratio` as plain binary, with bit 4 as the least significant bit.
- R6: A frame whose mode code is neither 1 nor 2 changes no output.
- R7: A frame with fewer or more than 21 bits changes no output.
- R8: Frames are loaded normally while `pwr_norm` is 0.
- R9: `port_out` is 1 when the latched port bit is 1, and 0 when it is 0.
- R10: A reference frame with the test bit set to 1 drives `test_flag` to 1 and loads every other field as normal. A later frame with the test bit at 0 clears `test_flag`.
- R11: A valid frame for one latch leaves every output of the other latch unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_ce | input | 1 | Serial chip enable; the frame is committed on its falling edge |
| ser_clk | input | 1 | Serial clock; data is sampled on its rising edge |
| ser_dat | input | 1 | Serial data, least significant bit first |
| ref_ratio | output | 12 | Reference-divider ratio |
| ref_div2 | output | 1 | Divide-by-two select for the reference path |
| pwr_norm | output | 1 | 1 = normal operation, 0 = power save |
| port_out | output | 1 | Level of the output-port pin |
| cp_en | output | 1 | 1 = charge pump active, 0 = high impedance |
| test_flag | output | 1 | Test bit from the last reference frame |
| prog_ratio | output | 17 | Programmable-divider ratio |

## Verification
A change on a serial pin passes through two synchronizer flops. The edge detector then acts on the third system-clock edge after the pin change, and the shift register or the latch updates on that same edge. Outputs therefore settle three cycles after the falling edge of `ser_ce`. The bench holds every serial level for at least three cycles, so each bit is sampled once. It reads the outputs on falling clock edges, eight cycles after chip enable drops, which is well past the three-cycle latency. Checks on discarded and cross-latch frames compare the outputs against the values the bench expects to remain after the frame.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
    localparam int MODE_W  = 4;
    localparam int REF_W   = 12;
    localparam int PROG_W  = 17;
    localparam int REF_PAY = REF_W + 5;
    localparam int PAY_W   = (REF_PAY > PROG_W) ? REF_PAY : PROG_W;
    localparam int FRAME_W = MODE_W + PAY_W;

    localparam logic [MODE_W-1:0] MODE_REF  = 4'd1;
    localparam logic [MODE_W-1:0] MODE_PROG = 4'd2;

    typedef struct packed {
        logic [REF_W-1:0]  ref_ratio;
        logic              ref_div2;
        logic              pwr_norm;
        logic              port_out;
        logic              cp_en;
        logic              test_flag;
        logic [PROG_W-1:0] prog_ratio;
    } ctl_regs_t;
endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] sync_d [STAGES];
    logic [W-1:0] sync_q [STAGES];

    always_comb begin
        sync_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            sync_d[i] = sync_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[g] <= '0;
                else        sync_q[g] <= sync_d[g];
            end
        end
    endgenerate

    assign dout = sync_q[STAGES-1];
endmodule

// File: rtl/sctl_shift.sv
module sctl_shift
    import sctl_pkg::*;
#(
    parameter int FW   = FRAME_W,
    parameter int CW   = $clog2(FW + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce,
    input  logic          sclk,
    input  logic          sdat,
    output logic [FW-1:0] frame_bits,
    output logic [CW-1:0] bit_cnt,
    output logic          commit
);
    localparam logic [CW-1:0] CNT_SAT = CW'(FW + 1);
    localparam logic [CW-1:0] CNT_FW  = CW'(FW);

    typedef struct packed {
        logic          prev_ce;
        logic          prev_sclk;
        logic [FW-1:0] bits;
        logic [CW-1:0] cnt;
    } shift_t;

    shift_t st_d, st_q;
    logic   ce_rise, sclk_rise;

    always_comb begin
        ce_rise      = ce & ~st_q.prev_ce;
        sclk_rise    = sclk & ~st_q.prev_sclk;
        st_d         = st_q;
        st_d.prev_ce   = ce;
        st_d.prev_sclk = sclk;
        if (ce_rise) begin
            st_d.cnt  = '0;
            st_d.bits = '0;
        end else if (ce && sclk_rise) begin
            if (st_q.cnt < CNT_FW) begin
                st_d.bits[st_q.cnt] = sdat;
            end
            if (st_q.cnt != CNT_SAT) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign frame_bits = st_q.bits;
    assign bit_cnt    = st_q.cnt;
    assign commit     = st_q.prev_ce & ~ce;

    AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && !st_q.prev_ce) |=> (bit_cnt == '0)); // R2
    AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce && st_q.prev_ce == 1'b0 && !$rose(ce)) |=> $stable(bit_cnt)); // R2
endmodule

// File: rtl/sctl_latch.sv
module sctl_latch
    import sctl_pkg::*;
#(
    parameter int FW = FRAME_W,
    parameter int CW = $clog2(FW + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          commit,
    input  logic [FW-1:0] frame_bits,
    input  logic [CW-1:0] bit_cnt,
    output ctl_regs_t     regs
);
    localparam int            REF_LEN  = MODE_W + REF_PAY;
    localparam int            PROG_LEN = MODE_W + PROG_W;
    localparam logic [CW-1:0] REF_CNT  = CW'(REF_LEN);
    localparam logic [CW-1:0] PROG_CNT = CW'(PROG_LEN);
    localparam int            P0       = MODE_W;

    ctl_regs_t        regs_d, regs_q;
    logic [MODE_W-1:0] mode;
    logic             take_ref, take_prog;

    always_comb begin
        mode      = frame_bits[MODE_W-1:0];
        take_ref  = commit && (mode == MODE_REF)  && (bit_cnt == REF_CNT);
        take_prog = commit && (mode == MODE_PROG) && (bit_cnt == PROG_CNT);
        regs_d    = regs_q;
        if (take_ref) begin
            regs_d.ref_ratio = frame_bits[P0 +: REF_W];
            regs_d.ref_div2  = frame_bits[P0 + REF_W];
            regs_d.pwr_norm  = frame_bits[P0 + REF_W + 1];
            regs_d.port_out  = frame_bits[P0 + REF_W + 2];
            regs_d.cp_en     = frame_bits[P0 + REF_W + 3];
            regs_d.test_flag = frame_bits[P0 + REF_W + 4];
        end
        if (take_prog) begin
            regs_d.prog_ratio = frame_bits[P0 +: PROG_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign regs = regs_q;

    AST_BAD_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && mode != MODE_REF && mode != MODE_PROG) |=> $stable(regs)); // R6
    AST_BAD_LEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && bit_cnt != REF_CNT && bit_cnt != PROG_CNT) |=> $stable(regs)); // R7
    AST_REF_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && mode == MODE_REF && bit_cnt == REF_CNT)
        |=> (regs.ref_ratio == $past(frame_bits[P0 +: REF_W]))
            && $stable(regs.prog_ratio)); // R4
    AST_PROG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && mode == MODE_PROG && bit_cnt == PROG_CNT)
        |=> (regs.prog_ratio == $past(frame_bits[P0 +: PROG_W]))
            && $stable(regs.ref_ratio) && $stable(regs.pwr_norm)); // R5
    AST_NO_COMMIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(regs)); // R11
endmodule

// File: rtl/sctl_rx.sv
module sctl_rx
    import sctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_ce,
    input  logic              ser_clk,
    input  logic              ser_dat,
    output logic [REF_W-1:0]  ref_ratio,
    output logic              ref_div2,
    output logic              pwr_norm,
    output logic              port_out,
    output logic              cp_en,
    output logic              test_flag,
    output logic [PROG_W-1:0] prog_ratio
);
    localparam int CW = $clog2(FRAME_W + 2);

    logic [2:0]         pins_s;
    logic [FRAME_W-1:0] frame_bits;
    logic [CW-1:0]      bit_cnt;
    logic               commit;
    ctl_regs_t          regs;

    sctl_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({ser_ce, ser_clk, ser_dat}),
        .dout (pins_s)
    );

    sctl_shift #(.FW(FRAME_W), .CW(CW)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce        (pins_s[2]),
        .sclk      (pins_s[1]),
        .sdat      (pins_s[0]),
        .frame_bits(frame_bits),
        .bit_cnt   (bit_cnt),
        .commit    (commit)
    );

    sctl_latch #(.FW(FRAME_W), .CW(CW)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (commit),
        .frame_bits(frame_bits),
        .bit_cnt   (bit_cnt),
        .regs      (regs)
    );

    assign ref_ratio  = regs.ref_ratio;
    assign ref_div2   = regs.ref_div2;
    assign pwr_norm   = regs.pwr_norm;
    assign port_out   = regs.port_out;
    assign cp_en      = regs.cp_en;
    assign test_flag  = regs.test_flag;
    assign prog_ratio = regs.prog_ratio;
endmodule

// File: tb/sctl_rx_test.sv
module sctl_rx_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_ce = 1'b0, ser_clk = 1'b0, ser_dat = 1'b0;
    logic [11:0] ref_ratio;
    logic        ref_div2, pwr_norm, port_out, cp_en, test_flag;
    logic [16:0] prog_ratio;

    int checks = 0;
    int failures = 0;
    logic [16:0] exp_ref_pay = '0;
    logic [16:0] exp_prog = '0;

    always #2 clk = ~clk;

    sctl_rx uut (
        .clk(clk), .rst_n(rst_n), .ser_ce(ser_ce), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .ref_ratio(ref_ratio), .ref_div2(ref_div2), .pwr_norm(pwr_norm), .port_out(port_out),
        .cp_en(cp_en), .test_flag(test_flag), .prog_ratio(prog_ratio)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [16:0] ref_pay(input logic [11:0] r, input logic d2, input logic ps,
                                            input logic o, input logic cp, input logic ts);
        return {ts, cp, o, ps, d2, r};
    endfunction

    task automatic send_frame(input logic [3:0] mode, input logic [16:0] pay, input int nbits);
        logic [20:0] word;
        word = {pay, mode};
        ser_ce = 1'b1;
        wait_clk(4);
        for (int i = 0; i < nbits; i++) begin
            ser_dat = (i < 21) ? word[i] : 1'b0;
            wait_clk(3);
            ser_clk = 1'b1;
            wait_clk(3);
            ser_clk = 1'b0;
            wait_clk(3);
        end
        ser_ce = 1'b0;
        wait_clk(8);
    endtask

    task automatic check_all(input string tag);
        check({tag, " ref_ratio"}, 32'(ref_ratio), 32'(exp_ref_pay[11:0]));
        check({tag, " ref_div2"},  32'(ref_div2),  32'(exp_ref_pay[12]));
        check({tag, " pwr_norm"},  32'(pwr_norm),  32'(exp_ref_pay[13]));
        check({tag, " port_out"},  32'(port_out),  32'(exp_ref_pay[14]));
        check({tag, " cp_en"},     32'(cp_en),     32'(exp_ref_pay[15]));
        check({tag, " test_flag"}, 32'(test_flag), 32'(exp_ref_pay[16]));
        check({tag, " prog_ratio"}, 32'(prog_ratio), 32'(exp_prog));
    endtask

    task automatic t_reset;
        check_all("R1 reset");
    endtask

    task automatic t_ref_load;
        exp_ref_pay = ref_pay(12'hA5C, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        send_frame(4'd1, exp_ref_pay, 21);
        check_all("R4 R3 R9 R11 ref load");
    endtask

    task automatic t_prog_load;
        exp_prog = 17'h1_2345;
        send_frame(4'd2, exp_prog, 21);
        check_all("R5 R11 prog load");
    endtask

    task automatic t_power_save;
        exp_ref_pay = ref_pay(12'h0F1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        send_frame(4'd1, exp_ref_pay, 21);
        check_all("R8 R9 ref in power save");
        exp_prog = 17'h0_ABCD;
        send_frame(4'd2, exp_prog, 21);
        check_all("R8 prog in power save");
    endtask

    task automatic t_bad_mode;
        send_frame(4'd7, 17'h1_FFFF, 21);
        check_all("R6 mode 7");
        send_frame(4'd0, 17'h0_5555, 21);
        check_all("R6 mode 0");
    endtask

    task automatic t_bad_len;
        send_frame(4'd2, 17'h0_1111, 20);
        check_all("R7 short");
        send_frame(4'd1, ref_pay(12'hFFF, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1), 22);
        check_all("R7 long");
    endtask

    task automatic t_ce_low_clocks;
        ser_ce = 1'b0;
        for (int i = 0; i < 5; i++) begin
            ser_dat = 1'b1;
            wait_clk(3);
            ser_clk = 1'b1;
            wait_clk(3);
            ser_clk = 1'b0;
            wait_clk(3);
        end
        wait_clk(6);
        check_all("R2 clocks with ce low");
        exp_prog = 17'h1_0001;
        send_frame(4'd2, exp_prog, 21);
        check_all("R2 frame after idle clocks");
    endtask

    task automatic t_test_bit;
        exp_ref_pay = ref_pay(12'h123, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
        send_frame(4'd1, exp_ref_pay, 21);
        check_all("R10 test bit set");
        exp_ref_pay = ref_pay(12'h800, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        send_frame(4'd1, exp_ref_pay, 21);
        check_all("R10 test bit clear");
    endtask

    initial begin
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(3);
        t_reset();
        t_ref_load();
        t_prog_load();
        t_power_save();
        t_bad_mode();
        t_bad_len();
        t_ce_low_clocks();
        t_test_bit();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule